// File: doc/BRIEF.md
# Floating Bus Value Sequencer

This block works out which byte a processor sees when it reads a port that no device drives, at a moment when the video controller is fetching display memory. The controller fetches in a fixed order inside every active display line. While that fetch runs, the bus carries the byte being fetched: a bitmap byte or an attribute byte. At every other moment the bus floats to the idle value 0xFF.

The block watches the frame t-state counter, which counts 0 to 70907 and advances by one each clock. It keeps the position of the current t-state inside the 192-line display window with a three-state machine:
- `ST_WAIT`: outside the window.
- `ST_FETCH`: the first 128 t-states of a window line.
- `ST_TAIL`: the remaining 100 t-states of a 228 t-state line.

The transitions are:
- **enter**: `ST_WAIT` to `ST_FETCH`, when the counter shows the t-state just before the window start (14364, which is three t-states after the contention window start at 14361).
- **tail**: `ST_FETCH` to `ST_TAIL`, after line position 127.
- **next line**: `ST_TAIL` to `ST_FETCH`, after position 227 of any line except the last.
- **leave**: `ST_TAIL` to `ST_WAIT`, after position 227 of line 191.

From the position, the block drives bitmap and attribute addresses to display memory. Memory returns the data bytes within the same cycle. On a read strobe, the block registers the chosen byte as the bus value.

Top module: `floatbus_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after reset is released, `bus_value` is 0xFF.
- R2: A read at a t-state before 14364, or at or after 14364 + 192*228 = 58140, returns 0xFF.
- R3: Inside the window, a read at line position p (p = (T-14364) mod 228) with p >= 128 returns 0xFF.
- R4: At p < 128, slot s = p mod 8 with s in 4..7 returns 0xFF.
- R5: Slot 0 of group g = p div 8 returns the bitmap byte of column c = 2g on line y = (T-14364) div 228. The bitmap address is {y[7:6], y[2:0], y[5:3], c[4:0]}, which is 13 bits.
- R6: Slot 1 returns the attribute byte of column 2g. The attribute address is {y[7:3], c[4:0]}, which is 10 bits.
- R7: Slots 2 and 3 return the bitmap byte and the attribute byte of column 2g+1, using the same address layouts.
- R8: A cycle with `rd_strobe` low leaves `bus_value` unchanged.
- R9: The value for a read made with t-state T presented is on `bus_value` after the clock edge that samples the strobe. It is held until the next read.
- R10: The window recurs in every frame after the counter wraps from 70907 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | t-state clock |
| rst_n | input | 1 | asynchronous active-low reset |
| tstate | input | 17 | frame t-state counter, 0..70907, +1 per clock |
| rd_strobe | input | 1 | processor read of an undriven port |
| pix_data | input | 8 | bitmap byte at `pix_addr` |
| attr_data | input | 8 | attribute byte at `attr_addr` |
| pix_addr | output | 13 | bitmap byte offset into display memory |
| attr_addr | output | 10 | attribute byte offset into attribute memory |
| bus_value | output | 8 | registered floating bus byte |

## Verification
The state registers load the position of T+1 while T is presented. As a result, the value for the t-state presented in cycle k lands on `bus_value` at edge k, one cycle after the strobe is driven.

The bench drives the counter and the strobe at falling edges. It checks each result at the next falling edge, before the next stimulus is applied, so every comparison sits exactly one edge after its strobe.

The sweep covers a full frame plus part of a second. The strobe is left low one cycle in seven, so that R8 holds are checked among the fetch slots.

// File: rtl/floatbus_pkg.sv
package floatbus_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_FETCH = 2'd1,
        ST_TAIL  = 2'd2
    } fb_state_e;

    typedef enum logic [1:0] {
        SK_IDLE   = 2'd0,
        SK_BITMAP = 2'd1,
        SK_ATTR   = 2'd2
    } fb_kind_e;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/floatbus_window_fsm.sv
module floatbus_window_fsm
    import floatbus_pkg::*;
#(
    parameter int TS_W      = 17,
    parameter int FRAME_LEN = 70908,
    parameter int WIN_START = 14364,
    parameter int LINE_LEN  = 228,
    parameter int ACTIVE    = 128,
    parameter int LINES     = 192,
    parameter int POS_W     = $clog2(LINE_LEN),
    parameter int LINE_W    = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   tstate,
    output fb_state_e         state_q,
    output logic [POS_W-1:0]  pos_q,
    output logic [LINE_W-1:0] line_q
);
    localparam int START_M1 = (WIN_START == 0) ? FRAME_LEN - 1 : WIN_START - 1;

    fb_state_e         state_n;
    logic [POS_W-1:0]  pos_n;
    logic [LINE_W-1:0] line_n;

    // state register: holds the position of the t-state presented next cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            pos_q   <= '0;
            line_q  <= '0;
        end else begin
            state_q <= state_n;
            pos_q   <= pos_n;
            line_q  <= line_n;
        end
    end

    always_comb begin
        state_n = state_q;
        pos_n   = pos_q;
        line_n  = line_q;
        unique case (state_q)
            ST_WAIT: begin
                if (tstate == TS_W'(START_M1)) begin
                    state_n = ST_FETCH;
                    pos_n   = '0;
                    line_n  = '0;
                end
            end
            ST_FETCH: begin
                pos_n = pos_q + 1'b1;
                if (pos_q == POS_W'(ACTIVE - 1))
                    state_n = ST_TAIL;
            end
            ST_TAIL: begin
                if (pos_q == POS_W'(LINE_LEN - 1)) begin
                    pos_n = '0;
                    if (line_q == LINE_W'(LINES - 1)) begin
                        state_n = ST_WAIT;
                    end else begin
                        line_n  = line_q + 1'b1;
                        state_n = ST_FETCH;
                    end
                end else begin
                    pos_n = pos_q + 1'b1;
                end
            end
            default: state_n = ST_WAIT;
        endcase
    end

    // R3
    tail_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TAIL |-> pos_q >= POS_W'(ACTIVE));

    // R2
    line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_WAIT |-> line_q <= LINE_W'(LINES - 1));

    // R10
    leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL && pos_q == POS_W'(LINE_LEN - 1) && line_q == LINE_W'(LINES - 1))
        |=> state_q == ST_WAIT);
endmodule

// File: rtl/floatbus_slot_decode.sv
module floatbus_slot_decode
    import floatbus_pkg::*;
#(
    parameter int ACT_W  = 7,
    parameter int LINE_W = 8,
    parameter int COL_W  = ACT_W - 2,
    parameter int PIX_W  = LINE_W + COL_W,
    parameter int ATR_W  = LINE_W - 3 + COL_W
) (
    input  fb_state_e         state,
    input  logic [ACT_W-1:0]  pos,
    input  logic [LINE_W-1:0] line,
    input  logic [7:0]        pix_data,
    input  logic [7:0]        attr_data,
    output logic [PIX_W-1:0]  pix_addr,
    output logic [ATR_W-1:0]  attr_addr,
    output fb_kind_e          kind,
    output logic [7:0]        value
);
    logic [COL_W-1:0] col;

    // two columns per 8-slot group: slots 0/1 the even one, slots 2/3 the odd one
    assign col = {pos[ACT_W-1:3], pos[1]};

    // bitmap rows interleave: third, pixel row in cell, cell row
    assign pix_addr  = {line[LINE_W-1:LINE_W-2], line[2:0], line[LINE_W-3:3], col};
    assign attr_addr = {line[LINE_W-1:3], col};

    always_comb begin
        kind = SK_IDLE;
        if (state == ST_FETCH) begin
            unique case (pos[2:0])
                3'd0, 3'd2: kind = SK_BITMAP;
                3'd1, 3'd3: kind = SK_ATTR;
                default:    kind = SK_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (kind)
            SK_BITMAP: value = pix_data;
            SK_ATTR:   value = attr_data;
            default:   value = IDLE_BYTE;
        endcase
    end

    // R5
    even_col_chk: assert final (!(state == ST_FETCH && pos[2:0] == 3'd0) || pix_addr[0] == 1'b0);
    // R7
    odd_col_chk: assert final (!(state == ST_FETCH && pos[2:1] == 2'd1) || attr_addr[0] == 1'b1);
endmodule

// File: rtl/floatbus_out_reg.sv
module floatbus_out_reg
    import floatbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_strobe,
    input  logic [7:0] value,
    output logic [7:0] bus_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_q <= IDLE_BYTE;
        else if (rd_strobe)
            bus_q <= value;
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(bus_q));

    // R9
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> bus_q == $past(value));
endmodule

// File: rtl/floatbus_seq.sv
module floatbus_seq
    import floatbus_pkg::*;
#(
    parameter int TS_W        = 17,
    parameter int FRAME_LEN   = 70908,
    parameter int CONT_START  = 14361,
    parameter int WIN_OFFSET  = 3,
    parameter int LINE_LEN    = 228,
    parameter int ACTIVE      = 128,
    parameter int LINES       = 192,
    parameter int PIX_AW      = 13,
    parameter int ATR_AW      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   tstate,
    input  logic              rd_strobe,
    input  logic [7:0]        pix_data,
    input  logic [7:0]        attr_data,
    output logic [PIX_AW-1:0] pix_addr,
    output logic [ATR_AW-1:0] attr_addr,
    output logic [7:0]        bus_value
);
    localparam int WIN_START = CONT_START + WIN_OFFSET;
    localparam int POS_W     = $clog2(LINE_LEN);
    localparam int LINE_W    = $clog2(LINES);
    localparam int ACT_W     = $clog2(ACTIVE);

    fb_state_e         state_q;
    logic [POS_W-1:0]  pos_q;
    logic [LINE_W-1:0] line_q;
    fb_kind_e          kind;
    logic [7:0]        slot_value;

    floatbus_window_fsm #(
        .TS_W(TS_W), .FRAME_LEN(FRAME_LEN), .WIN_START(WIN_START),
        .LINE_LEN(LINE_LEN), .ACTIVE(ACTIVE), .LINES(LINES),
        .POS_W(POS_W), .LINE_W(LINE_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .tstate(tstate),
        .state_q(state_q), .pos_q(pos_q), .line_q(line_q)
    );

    floatbus_slot_decode #(
        .ACT_W(ACT_W), .LINE_W(LINE_W),
        .COL_W(ACT_W - 2), .PIX_W(PIX_AW), .ATR_W(ATR_AW)
    ) u_dec (
        .state(state_q), .pos(pos_q[ACT_W-1:0]), .line(line_q),
        .pix_data(pix_data), .attr_data(attr_data),
        .pix_addr(pix_addr), .attr_addr(attr_addr),
        .kind(kind), .value(slot_value)
    );

    floatbus_out_reg u_out (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
        .value(slot_value), .bus_q(bus_value)
    );

    // R2
    outside_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state_q == ST_WAIT) |=> bus_value == IDLE_BYTE);

    // R4
    late_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state_q == ST_FETCH && pos_q[2]) |=> bus_value == IDLE_BYTE);

    // R3
    tail_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state_q == ST_TAIL) |=> bus_value == IDLE_BYTE);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> bus_value == IDLE_BYTE);

    // R5
    fetch_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && pos_q[2:0] == 3'd0) |-> kind == SK_BITMAP);
endmodule

// File: tb/floatbus_seq_test.sv
module floatbus_seq_test;
    localparam int FRAME = 70908;
    localparam int WSTART = 14364;
    localparam int WLEN = 192 * 228;
    localparam int NCYC = FRAME + 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] tstate = '0;
    logic        rd_strobe = 1'b0;
    logic [7:0]  pix_data, attr_data;
    logic [12:0] pix_addr;
    logic [9:0]  attr_addr;
    logic [7:0]  bus_value;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    floatbus_seq uut (
        .clk(clk), .rst_n(rst_n), .tstate(tstate), .rd_strobe(rd_strobe),
        .pix_data(pix_data), .attr_data(attr_data),
        .pix_addr(pix_addr), .attr_addr(attr_addr), .bus_value(bus_value)
    );

    // memory model: each byte is a fixed function of its address
    always_comb begin
        pix_data  = pix_addr[7:0] + {pix_addr[12:8], 3'b101};
        attr_data = ~attr_addr[7:0] ^ {attr_addr[9:8], 6'h2A};
    end

    function automatic logic [7:0] pix_byte(int a);
        return 8'(((a & 255) + ((((a >> 8) & 31) << 3) | 5)) & 255);
    endfunction

    function automatic logic [7:0] attr_byte(int a);
        return 8'(((~a) & 255) ^ ((((a >> 8) & 3) << 6) | 42));
    endfunction

    function automatic logic [7:0] expect_at(int t);
        int d, y, p, s, c, pa, aa;
        d = t - WSTART;
        if (d < 0 || d >= WLEN) return 8'hFF;
        y = d / 228;
        p = d % 228;
        if (p >= 128) return 8'hFF;
        s = p % 8;
        if (s >= 4) return 8'hFF;
        c = 2 * (p / 8) + ((s >= 2) ? 1 : 0);
        pa = ((y & 8'hC0) << 5) | ((y & 7) << 8) | ((y & 8'h38) << 2) | c;
        aa = ((y >> 3) << 5) | c;
        return ((s % 2) == 0) ? pix_byte(pa) : attr_byte(aa);
    endfunction

    function automatic string tag_at(int t, bit rd, bit second);
        int d, p;
        if (!rd) return "R8";
        d = t - WSTART;
        if (d < 0 || d >= WLEN) return second ? "R10" : "R2";
        p = d % 228;
        if (p >= 128) return "R3";
        if ((p % 8) >= 4) return "R4";
        if ((p % 8) == 0) return second ? "R10" : "R5";
        if ((p % 8) == 1) return "R6";
        return "R7";
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: bus_value=%02h expected %02h", req, act, exp);
        end
    endtask

    initial begin
        int prev_t;
        bit prev_rd;
        bit have_prev;
        logic [7:0] held;
        have_prev = 1'b0;
        held = 8'hFF;
        prev_t = 0;
        prev_rd = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", bus_value, 8'hFF);
        rst_n = 1'b1;
        check("R1", bus_value, 8'hFF);
        for (int k = 0; k < NCYC; k++) begin
            @(negedge clk);
            // R9: result of the strobe driven one edge earlier is checked now
            if (have_prev) begin
                if (prev_rd) held = expect_at(prev_t);
                check(tag_at(prev_t, prev_rd, (k - 1) >= FRAME), bus_value, held);
            end
            prev_t = k % FRAME;
            prev_rd = ((k % 7) != 3);
            have_prev = 1'b1;
            tstate = 17'(prev_t);
            rd_strobe = prev_rd;
        end
        @(negedge clk);
        if (prev_rd) held = expect_at(prev_t);
        check(tag_at(prev_t, prev_rd, 1'b1), bus_value, held);
        // R1: reset mid-fetch forces the idle value
        rst_n = 1'b0;
        rd_strobe = 1'b1;
        @(negedge clk);
        check("R1", bus_value, 8'hFF);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (NCYC + 200) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule